// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the SPI slave front end that answers the two identification commands of a serial flash. It oversamples chip select, serial clock and serial input on the system clock and decodes the 8-bit opcode that follows a chip-select fall. It then shifts identification bytes out MSB first. The serial output is only a data bit plus an output enable. The enable stays low whenever the block is not driving, which stands for the high-impedance state of the pad.

The first identification command returns four bytes and keeps cycling through them while the master keeps clocking. The four bytes are a manufacturer code, a memory type, a capacity code and a reserved byte. The second command expects three dummy bytes after the opcode and then returns a single device byte over and over. A busy input from the write/erase engine makes the block ignore either command. All codes and opcodes are parameters. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work, because input is taken on rising edges and output changes on falling edges.

Top module: `spi_id_resp`

## Requirements
- R1: While chip select is high, and after reset, `so_oe` is low, and every transaction starts afresh from the opcode.
- R2: Opcode 9Fh gives bytes 62h, 06h, 13h, 00h. Bit 7 of 62h is driven on the first falling SCK edge after the eighth opcode bit.
- R3: After opcode 9Fh, the four-byte sequence 62h, 06h, 13h, 00h repeats for as long as SCK keeps toggling.
- R4: Opcode ABh is followed by 24 don't-care bits, during which `so_oe` stays low. Byte 6Eh is then driven, with bit 7 on the falling edge after the last dummy bit.
- R5: After opcode ABh and its dummy bits, 6Eh is driven again on every byte slot until chip select rises.
- R6: If `busy` is high when the eighth opcode bit is taken, the command is ignored and `so_oe` stays low until chip select rises.
- R7: An opcode other than 9Fh or ABh leaves `so_oe` low until chip select rises.
- R8: `so` and `so_oe` change only in response to a falling SCK edge or chip select going high, and bytes go out MSB first.
- R9: Raising chip select in the middle of an opcode or an output byte ends the transaction, and the next command is decoded correctly.
- R10: Both commands give the same results whether SCK idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in, taken on rising SCK |
| busy | input | 1 | High while a write or erase is in progress |
| so | output | 1 | Serial data out, updated on falling SCK |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The table covers both ID opcodes in mode 0 and mode 3. Each run reads nine byte slots. This shows whether the four-byte cycle wraps at the right point and whether the single device byte keeps repeating. The same opcodes are sent with busy high, and unknown opcodes (03h, and 9Eh, which is one bit away from 9Fh) are sent as well. None of these may turn on the driver. That separates real decoding from partial matching. Directed runs raise chip select in the middle of the opcode and in the middle of an output byte, then check that the next command is decoded correctly.

// File: rtl/spi_id_resp.sv
module spi_id_resp #(
  parameter logic [7:0] OP_JEDEC   = 8'h9F,
  parameter logic [7:0] OP_DEVID   = 8'hAB,
  parameter logic [7:0] MFR_CODE   = 8'h62,
  parameter logic [7:0] MEM_TYPE   = 8'h06,
  parameter logic [7:0] CAP_CODE   = 8'h13,
  parameter logic [7:0] RSVD_CODE  = 8'h00,
  parameter logic [7:0] DEV_CODE   = 8'h6E,
  parameter int         DUMMY_BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic busy,
  output logic so,
  output logic so_oe
);
  localparam int CW = $clog2((DUMMY_BITS > 8 ? DUMMY_BITS : 8) + 1);
  localparam logic [1:0] ST_CMD = 2'd0, ST_DUMMY = 2'd1, ST_OUT = 2'd2, ST_DEAD = 2'd3;

  logic [2:0] sck_p;
  logic [1:0] cs_p, si_p;
  logic       cs_s, si_s, sck_rise, sck_fall;
  logic [1:0] state;
  logic [6:0] sh;
  logic [CW-1:0] cnt;
  logic [4:0] pos;
  logic       jedec;
  logic [7:0] opc, out_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= 2'b11;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p  <= {cs_p[0], cs_n};
      si_p  <= {si_p[0], si};
    end

  assign cs_s     = cs_p[1];
  assign si_s     = si_p[1];
  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign opc      = {sh, si_s};

  always_comb
    if (!jedec) out_byte = DEV_CODE;
    else case (pos[4:3])
      2'd0:    out_byte = MFR_CODE;
      2'd1:    out_byte = MEM_TYPE;
      2'd2:    out_byte = CAP_CODE;
      default: out_byte = RSVD_CODE;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_CMD;
      sh    <= '0;
      cnt   <= '0;
      pos   <= '0;
      jedec <= 1'b0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (cs_s) begin
      state <= ST_CMD;
      cnt   <= '0;
      pos   <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      case (state)
        ST_CMD:
          if (sck_rise) begin
            sh  <= opc[6:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt <= '0;
              if (busy)                state <= ST_DEAD;
              else if (opc == OP_JEDEC) begin jedec <= 1'b1; state <= ST_OUT;   end
              else if (opc == OP_DEVID) begin jedec <= 1'b0; state <= ST_DUMMY; end
              else                     state <= ST_DEAD;
            end
          end
        ST_DUMMY:
          if (sck_rise) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DUMMY_BITS - 1)) state <= ST_OUT;
          end
        ST_OUT:
          if (sck_fall) begin
            so    <= out_byte[~pos[2:0]];
            so_oe <= 1'b1;
            pos   <= pos + 1'b1;
          end
        default: ;
      endcase
    end
endmodule

// File: rtl/spi_id_resp_chk.sv
module spi_id_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_fall,
  input logic [1:0] state,
  input logic       so,
  input logic       so_oe
);
  assert_deselect_hz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);

  assert_quiet_outside_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd2) |-> !so_oe);

  assert_stable_between_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !sck_fall) |=> ($stable(so) && $stable(so_oe)));

  assert_drive_starts_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));
endmodule

bind spi_id_resp spi_id_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_fall(sck_fall),
  .state(state), .so(so), .so_oe(so_oe)
);

// File: tb/sim_spi_id_resp.sv
module sim_spi_id_resp;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int NVEC = 8;
  // {opcode, busy, mode3, expected kind: 0 none, 1 four-byte, 2 device byte}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h9F, 1'b0, 1'b0, 2'd1}, {8'h9F, 1'b0, 1'b1, 2'd1},
    {8'hAB, 1'b0, 1'b0, 2'd2}, {8'hAB, 1'b0, 1'b1, 2'd2},
    {8'h9F, 1'b1, 1'b0, 2'd0}, {8'hAB, 1'b1, 1'b1, 2'd0},
    {8'h03, 1'b0, 1'b0, 2'd0}, {8'h9E, 1'b0, 1'b1, 2'd0}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, busy = 0;
  logic so, so_oe;
  int checks = 0, fails = 0;
  logic mode3 = 0;

  spi_id_resp u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                  .busy(busy), .so(so), .so_oe(so_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic bit_x(input logic b, output logic r, output logic d);
    @(negedge clk); sck = 0; si = b;
    repeat (H) @(negedge clk);
    r = so; d = so_oe;
    sck = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] r, output logic all_d, output logic any_d);
    logic rb, db;
    all_d = 1; any_d = 0; r = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(b[i], rb, db);
      r[i] = rb; all_d &= db; any_d |= db;
    end
  endtask

  task automatic begin_tx(input logic m3);
    mode3 = m3;
    @(negedge clk); sck = m3;
    repeat (H) @(negedge clk);
    cs_n = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic end_tx(input string req);
    @(negedge clk); sck = mode3;
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (H) @(negedge clk);
    chk(!so_oe, req, {7'd0, so_oe}, 8'h00);
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] kind, input int i);
    if (kind == 2'd2) return 8'h6E;
    case (i % 4)
      0: return 8'h62;
      1: return 8'h06;
      2: return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic ad, yd, anyhz;
    repeat (4) @(negedge clk);
    chk(!so_oe, "R1 reset", {7'd0, so_oe}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!so_oe, "R1 idle", {7'd0, so_oe}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op;
      logic [1:0] kind;
      op = VEC[v][11:4]; busy = VEC[v][3]; kind = VEC[v][1:0];
      begin_tx(VEC[v][2]);
      byte_x(op, r, ad, yd);
      anyhz = yd;
      if (op == 8'hAB)
        for (int k = 0; k < 3; k++) begin byte_x(8'hA5, r, ad, yd); anyhz |= yd; end
      chk(!anyhz, (op == 8'hAB) ? "R4 hz during opcode/dummy" : "R2 hz during opcode", {7'd0, anyhz}, 8'h00);
      busy = 0;
      for (int i = 0; i < 9; i++) begin
        byte_x(8'h00, r, ad, yd);
        if (kind == 2'd0)
          chk(!yd, VEC[v][3] ? "R6 busy no drive" : "R7 unknown opcode no drive", {7'd0, yd}, 8'h00);
        else
          chk(ad && r == exp_byte(kind, i),
              kind == 2'd1 ? (i < 4 ? "R2 R10 id sequence" : "R3 R10 repeat") :
                             (i == 0 ? "R4 R10 device byte" : "R5 R10 repeat"),
              r, exp_byte(kind, i));
      end
      end_tx("R1 deselect hz");
    end

    // R9: abort in the middle of an output byte, then a fresh command
    begin_tx(0);
    byte_x(8'h9F, r, ad, yd);
    for (int i = 0; i < 4; i++) begin logic rb, db; bit_x(0, rb, db); end
    end_tx("R9 abort mid byte hz");
    begin_tx(0);
    byte_x(8'hAB, r, ad, yd);
    for (int k = 0; k < 3; k++) byte_x(8'h00, r, ad, yd);
    byte_x(8'h00, r, ad, yd);
    chk(ad && r == 8'h6E, "R9 fresh decode after abort", r, 8'h6E);
    end_tx("R1 deselect hz");

    // R9: abort in the middle of the opcode in mode 3
    begin_tx(1);
    for (int i = 7; i >= 4; i--) begin logic rb, db; bit_x(r9_op(i), rb, db); end
    end_tx("R9 abort mid opcode hz");
    begin_tx(1);
    byte_x(8'h9F, r, ad, yd);
    byte_x(8'h00, r, ad, yd);
    chk(ad && r == 8'h62, "R9 R10 first byte after opcode abort", r, 8'h62);
    end_tx("R1 deselect hz");

    finish_run();
  end

  function automatic logic r9_op(input int i);
    logic [7:0] o = 8'hAB;
    return o[i];
  endfunction
endmodule